// File: doc/BRIEF.md
# Duplicated-Table Fault-Tolerant State Machine

This block runs a finite state machine whose whole behaviour lives in a lookup table instead of in gates. The table sits in two identical synchronous memories, called copy A and copy B. The current state sits in the upper address bits and the input vector in the lower address bits. Each stored word holds the next state, the output vector and an even-parity bit. On every clock both copies are read at the same address and their words are compared. When the words agree and parity holds, the machine steps normally.

When the two words differ and exactly one of them passes parity, the block takes the passing word and raises an error flag. It then rewrites the failing copy at the same address during the following cycle, and the machine does not stop. A disagreement that parity cannot settle is reported as uncorrectable, and in that case the state is not advanced. The same holds for two identical words that both fail parity. The table is loaded through a load port while reset is held. A fault-injection port flips chosen bits in either copy, or in both, so that detection and repair can be exercised.

Top module: `ftfsm_duplex`

## Requirements
- R1: While `rst` is high, and in the cycle right after its release before the first read has completed, `out_o`, `err_o` and `unc_o` are 0 and the current state is 0.
- R2: While `rst` is high, `ld_we` writes `ld_data` to address `ld_addr` in both copies. In `ld_data`, bits 6:4 are the next state and bits 3:0 are the outputs. The block appends even parity as word bit 7. An address is {state in bits 4:2, input in bits 1:0}.
- R3: At each clock edge with `rst` low, the word at {current state, `in_i`} is read. After that edge, `out_o` shows the word's output field and the current state becomes its next-state field.
- R4: `ld_we` has no effect while `rst` is low.
- R5: If the two words differ, one passes parity and the other fails, then in that cycle `err_o`=1 and `unc_o`=0, and the outputs and next state come from the passing word.
- R6: The passing word is written into the failing copy, at the same address, at the edge that ends the cycle after detection. A read of that address at that edge or later returns the repaired word, because write data is forwarded to a same-edge read.
- R7: If both words pass parity yet differ, or both fail parity, then `unc_o`=1. The current state is held, `out_o` keeps its previous value and no write-back is issued.
- R8: When `inj_en` is high at an edge, `inj_mask` is XORed into the word at `inj_addr` in each copy selected by `inj_copy` (bit 0 selects copy A, bit 1 selects copy B). The mask positions follow the word layout: bit 7 is parity, bits 6:4 are the next state, bits 3:0 are the outputs. A read at the same edge sees the word as it was before the flip.
- R9: `err_o` is 1 exactly in the cycles where the two presented words differ, including an uncorrectable difference. Two identical words give `err_o`=0, even when both fail parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also enables table loading |
| in_i | input | 2 | Input vector, lower address bits |
| out_o | output | 4 | Output vector from the selected word |
| err_o | output | 1 | The two copies disagree this cycle |
| unc_o | output | 1 | Disagreement or corruption that parity cannot resolve |
| ld_we | input | 1 | Table write strobe, honoured only under reset |
| ld_addr | input | 5 | Table address {state, input} |
| ld_data | input | 7 | {next state, outputs}, without parity |
| inj_en | input | 1 | Fault-injection strobe |
| inj_copy | input | 2 | Copies to corrupt (bit 0 A, bit 1 B) |
| inj_addr | input | 5 | Address to corrupt |
| inj_mask | input | 8 | Bits to flip in the stored word |

## Verification
The bench flips a single bit in copy B and then the same bit in copy A at the same address. If the repair had been lost or sent to the wrong copy, the second fault would show up as an uncorrectable identical pair rather than a clean correction. Next-state bits are corrupted on a step with a nonzero input, so a design that took the failing copy's word would land in a visibly wrong state. The uncorrectable cases are triggered on a step whose stored output differs from the previous output, so a design that advanced, or that used either word, would show a changed `out_o`. A stray load strobe during run time, and a corrupted pair that is identical but fails parity, confirm that neither writes nor `err_o` leak through.

// File: rtl/ftfsm_pkg.sv
package ftfsm_pkg;

    localparam int ST_W   = 3;
    localparam int IN_W   = 2;
    localparam int OUT_W  = 4;
    localparam int COPIES = 2;
    localparam int ADDR_W = ST_W + IN_W;
    localparam int PAY_W  = ST_W + OUT_W;
    localparam int WORD_W = PAY_W + 1;

    typedef logic [ST_W-1:0] state_t;

    typedef struct packed {
        logic             par;
        state_t           nxt;
        logic [OUT_W-1:0] outs;
    } word_t;

    typedef enum logic [1:0] {
        V_CLEAN = 2'd0,
        V_FIX_A = 2'd1,
        V_FIX_B = 2'd2,
        V_FATAL = 2'd3
    } verdict_e;

    function automatic word_t make_word(input logic [PAY_W-1:0] pay);
        word_t w;
        {w.nxt, w.outs} = pay;
        w.par = ^pay;
        return w;
    endfunction

    function automatic logic parity_ok(input word_t w);
        return (^{w.par, w.nxt, w.outs}) == 1'b0;
    endfunction

endpackage

// File: rtl/ftfsm_mem.sv
module ftfsm_mem #(
    parameter int AW = 5,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          flip_en,
    input  logic [AW-1:0] flip_addr,
    input  logic [DW-1:0] flip_mask,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (wr_addr == rd_addr)) begin
            rd_data <= wr_data;
        end else begin
            rd_data <= mem[rd_addr];
        end
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        if (flip_en) begin
            mem[flip_addr] <= ((wr_en && (wr_addr == flip_addr)) ? wr_data : mem[flip_addr]) ^ flip_mask;
        end
    end

endmodule

// File: rtl/ftfsm_judge.sv
module ftfsm_judge
    import ftfsm_pkg::*;
(
    input  logic              valid,
    input  word_t             word_a,
    input  word_t             word_b,
    output verdict_e          verdict,
    output word_t             good_w,
    output logic              mismatch,
    output logic              fix_req,
    output logic [COPIES-1:0] fix_copy
);
    logic pa, pb, same;

    always_comb begin
        pa   = parity_ok(word_a);
        pb   = parity_ok(word_b);
        same = (word_a == word_b);
        good_w  = word_a;
        verdict = V_CLEAN;
        if (valid) begin
            if (same) begin
                verdict = pa ? V_CLEAN : V_FATAL;
            end else if (pa && !pb) begin
                verdict = V_FIX_B;
            end else if (!pa && pb) begin
                verdict = V_FIX_A;
                good_w  = word_b;
            end else begin
                verdict = V_FATAL;
            end
        end
        mismatch = valid && !same;
        fix_req  = (verdict == V_FIX_A) || (verdict == V_FIX_B);
        fix_copy = '0;
        if (verdict == V_FIX_A) fix_copy[0] = 1'b1;
        if (verdict == V_FIX_B) fix_copy[1] = 1'b1;
    end

endmodule

// File: rtl/ftfsm_repair.sv
module ftfsm_repair
    import ftfsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [PAY_W-1:0]  ld_data,
    input  logic              fix_req,
    input  logic [COPIES-1:0] fix_copy,
    input  logic [ADDR_W-1:0] fix_addr,
    input  word_t             fix_word,
    output logic [COPIES-1:0] wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output word_t             wr_data
);
    logic [COPIES-1:0] pend_q;
    logic [ADDR_W-1:0] addr_q;
    word_t             word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= fix_req ? fix_copy : '0;
            if (fix_req) begin
                addr_q <= fix_addr;
                word_q <= fix_word;
            end
        end
    end

    always_comb begin
        if (rst) begin
            wr_en   = {COPIES{ld_we}};
            wr_addr = ld_addr;
            wr_data = make_word(ld_data);
        end else begin
            wr_en   = pend_q;
            wr_addr = addr_q;
            wr_data = word_q;
        end
    end

    a_r6_one_copy_fixed: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_en));

    a_r6_fix_word_clean: assert property (@(posedge clk) disable iff (rst)
        (|wr_en) |-> parity_ok(wr_data));

endmodule

// File: rtl/ftfsm_duplex.sv
module ftfsm_duplex
    import ftfsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IN_W-1:0]   in_i,
    output logic [OUT_W-1:0]  out_o,
    output logic              err_o,
    output logic              unc_o,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [PAY_W-1:0]  ld_data,
    input  logic              inj_en,
    input  logic [COPIES-1:0] inj_copy,
    input  logic [ADDR_W-1:0] inj_addr,
    input  logic [WORD_W-1:0] inj_mask
);
    logic [WORD_W-1:0] rd_raw [COPIES];
    word_t             rd_w   [COPIES];
    logic [COPIES-1:0] wr_en;
    logic [ADDR_W-1:0] wr_addr;
    word_t             wr_data;

    state_t            state_q, cur_state;
    logic [OUT_W-1:0]  out_q;
    logic              rd_vld, rst_d, use_w;
    logic [ADDR_W-1:0] addr_q, rd_addr;

    verdict_e          verdict;
    word_t             good_w;
    logic              mismatch, fix_req;
    logic [COPIES-1:0] fix_copy;

    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        ftfsm_mem #(.AW(ADDR_W), .DW(WORD_W)) u_mem (
            .clk       (clk),
            .wr_en     (wr_en[c]),
            .wr_addr   (wr_addr),
            .wr_data   (WORD_W'(wr_data)),
            .flip_en   (inj_en && inj_copy[c]),
            .flip_addr (inj_addr),
            .flip_mask (inj_mask),
            .rd_addr   (rd_addr),
            .rd_data   (rd_raw[c])
        );
        assign rd_w[c] = word_t'(rd_raw[c]);
    end

    ftfsm_judge u_judge (
        .valid    (rd_vld),
        .word_a   (rd_w[0]),
        .word_b   (rd_w[1]),
        .verdict  (verdict),
        .good_w   (good_w),
        .mismatch (mismatch),
        .fix_req  (fix_req),
        .fix_copy (fix_copy)
    );

    ftfsm_repair u_repair (
        .clk      (clk),
        .rst      (rst),
        .ld_we    (ld_we),
        .ld_addr  (ld_addr),
        .ld_data  (ld_data),
        .fix_req  (fix_req),
        .fix_copy (fix_copy),
        .fix_addr (addr_q),
        .fix_word (good_w),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    always_comb begin
        use_w     = rd_vld && (verdict != V_FATAL);
        cur_state = use_w ? good_w.nxt  : state_q;
        out_o     = use_w ? good_w.outs : out_q;
        rd_addr   = {cur_state, in_i};
        err_o     = mismatch;
        unc_o     = rd_vld && (verdict == V_FATAL);
    end

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            state_q <= '0;
            out_q   <= '0;
            rd_vld  <= 1'b0;
            addr_q  <= '0;
        end else begin
            state_q <= cur_state;
            out_q   <= out_o;
            rd_vld  <= 1'b1;
            addr_q  <= rd_addr;
        end
    end

    a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (rst)
        rst_d |-> (state_q == '0 && out_o == '0 && !err_o && !unc_o));

    a_r3_next_addr: assert property (@(posedge clk) disable iff (rst)
        (rd_vld && !unc_o) |=> (addr_q[ADDR_W-1 -: ST_W] == $past(good_w.nxt)));

    a_r5_good_parity: assert property (@(posedge clk) disable iff (rst)
        (rd_vld && !unc_o) |-> parity_ok(good_w));

    a_r7_state_held: assert property (@(posedge clk) disable iff (rst)
        unc_o |=> (state_q == $past(state_q)));

endmodule

// File: tb/sim_ftfsm_duplex.sv
module sim_ftfsm_duplex;
    import ftfsm_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic [IN_W-1:0]   in_i;
    logic [OUT_W-1:0]  out_o;
    logic              err_o, unc_o;
    logic              ld_we;
    logic [ADDR_W-1:0] ld_addr;
    logic [PAY_W-1:0]  ld_data;
    logic              inj_en;
    logic [COPIES-1:0] inj_copy;
    logic [ADDR_W-1:0] inj_addr;
    logic [WORD_W-1:0] inj_mask;

    int     checks = 0;
    int     fails  = 0;
    bit     done   = 0;
    state_t ms;

    localparam int NVEC = 12;
    localparam logic [IN_W-1:0] VEC [NVEC] = '{2'd1, 2'd2, 2'd3, 2'd0, 2'd1, 2'd1,
                                               2'd3, 2'd2, 2'd0, 2'd2, 2'd3, 2'd1};

    ftfsm_duplex u0 (
        .clk(clk), .rst(rst), .in_i(in_i), .out_o(out_o), .err_o(err_o), .unc_o(unc_o),
        .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .inj_en(inj_en), .inj_copy(inj_copy), .inj_addr(inj_addr), .inj_mask(inj_mask)
    );

    always #4 clk = ~clk;

    function automatic state_t m_nxt(input state_t s, input logic [IN_W-1:0] i);
        return (i == '0) ? s : state_t'(s + state_t'(i));
    endfunction

    function automatic logic [OUT_W-1:0] m_out(input state_t s, input logic [IN_W-1:0] i);
        return {s, ^i};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_all();
        rst   = 1'b1;
        ld_we = 1'b1;
        for (int a = 0; a < (1 << ADDR_W); a++) begin
            logic [ADDR_W-1:0] av;
            av      = ADDR_W'(a);
            ld_addr = av;
            ld_data = {m_nxt(av[ADDR_W-1:IN_W], av[IN_W-1:0]), m_out(av[ADDR_W-1:IN_W], av[IN_W-1:0])};
            @(negedge clk);
        end
        ld_we = 1'b0;
    endtask

    task automatic step_chk(input logic [IN_W-1:0] v, input string req);
        logic [OUT_W-1:0] eo;
        in_i = v;
        eo   = m_out(ms, v);
        ms   = m_nxt(ms, v);
        @(negedge clk);
        chk(req, out_o, eo);
        chk(req, err_o, 0);
        chk(req, unc_o, 0);
    endtask

    task automatic inject(input logic [COPIES-1:0] cp, input logic [ADDR_W-1:0] a,
                          input logic [WORD_W-1:0] m);
        in_i     = '0;
        inj_en   = 1'b1;
        inj_copy = cp;
        inj_addr = a;
        inj_mask = m;
        @(negedge clk);
        inj_en = 1'b0;
    endtask

    task automatic hold_chk(input int e_err, input string req);
        in_i = '0;
        @(negedge clk);
        chk(req, err_o, e_err);
        chk(req, unc_o, 0);
        chk(req, out_o, m_out(ms, '0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_i = '0; ld_we = 1'b0; ld_addr = '0; ld_data = '0;
        inj_en = 1'b0; inj_copy = '0; inj_addr = '0; inj_mask = '0;
        @(negedge clk);
        @(negedge clk);
        load_all();                                     // R2 table load under reset
        chk("R1 reset out", out_o, 0);
        chk("R1 reset err", err_o, 0);
        chk("R1 reset unc", unc_o, 0);
        in_i = VEC[0];
        rst  = 1'b0;
        #1;
        chk("R1 first cycle out", out_o, 0);
        ms = '0;

        // R3/R2 table walk
        for (int k = 0; k < NVEC; k++) begin
            step_chk(VEC[k], "R3 walk");
        end

        // R4 load strobe ignored while running
        in_i    = '0;
        ld_we   = 1'b1;
        ld_addr = {ms, 2'd1};
        ld_data = ~{m_nxt(ms, 2'd1), m_out(ms, 2'd1)};
        @(negedge clk);
        ld_we = 1'b0;
        step_chk(2'd1, "R4 stray load");

        // R5/R6/R8/R9: single-bit fault in copy B, then repair
        inject(2'b10, {ms, 2'd0}, 8'h01);
        hold_chk(1, "R5 detect copy B");
        hold_chk(1, "R9 still differs before repair");
        hold_chk(0, "R6 repaired copy B");
        // same bit in copy A: clean correction only if B really was rewritten
        inject(2'b01, {ms, 2'd0}, 8'h01);
        hold_chk(1, "R6 copy B repair proven");
        hold_chk(1, "R5 copy A bad");
        hold_chk(0, "R6 repaired copy A");

        // R5: next-state bit corrupt in copy A, good copy must steer
        inject(2'b01, {ms, 2'd1}, 8'h10);
        in_i = 2'd1;
        @(negedge clk);
        chk("R5 nxt fault err", err_o, 1);
        chk("R5 nxt fault unc", unc_o, 0);
        chk("R5 nxt fault out", out_o, m_out(ms, 2'd1));
        ms = m_nxt(ms, 2'd1);
        step_chk(2'd2, "R5 state from good copy");

        // R7: both parity-clean but differ (two next-state bits in B)
        inject(2'b10, {ms, 2'd2}, 8'h30);
        in_i = 2'd2;
        @(negedge clk);
        chk("R7 differ unc", unc_o, 1);
        chk("R9 differ err", err_o, 1);
        chk("R7 differ out held", out_o, m_out(ms, 2'd0));
        step_chk(2'd1, "R7 state held");

        // R7/R9: identical corruption in both copies
        inject(2'b11, {ms, 2'd3}, 8'h01);
        in_i = 2'd3;
        @(negedge clk);
        chk("R7 both bad unc", unc_o, 1);
        chk("R9 identical err", err_o, 0);
        chk("R7 both bad out held", out_o, m_out(ms, 2'd0));
        step_chk(2'd2, "R7 resume");

        // R1/R2: reset mid-run and reload
        rst  = 1'b1;
        in_i = 2'd1;
        @(negedge clk);
        chk("R1 mid reset out", out_o, 0);
        chk("R1 mid reset err", err_o, 0);
        chk("R1 mid reset unc", unc_o, 0);
        load_all();
        in_i = 2'd2;
        rst  = 1'b0;
        #1;
        chk("R1 release out", out_o, 0);
        ms = '0;
        step_chk(2'd2, "R2 reload");
        step_chk(2'd1, "R2 reload");
        step_chk(2'd0, "R2 reload");
        step_chk(2'd3, "R2 reload");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule